// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

The block derives an SPI serial clock from the system clock. A prescaler divides the system clock first. It produces a one-cycle advance tick every `pre_i + 1` cycles. An inner phase counter moves on each tick. It counts from zero up to `cnt_n_i` and then wraps. Two programmable compare points set the edges: the raw clock goes high when the counter reaches `cnt_h_i` and low when it reaches `cnt_l_i`. Every field is programmed as its intended value minus one. A bypass control passes the system clock straight to the output and ignores all divider fields.

The clock runs only while `active_i` is high. When it drops, both counters clear and the output returns to its idle level on the next edge. `idle_high_i` sets the idle level. `late_edge_i` selects the data phase. Together these two inputs cover the four SPI clock modes.

Alongside the clock, the block drives two one-cycle strobes for a shifter: `launch_o` (drive the next bit) and `sample_o` (capture the incoming bit). Each strobe rises in the same cycle as the clock transition it marks.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `rst_ni` is low, and afterwards while `active_i` is low, `sclk_o` equals `idle_high_i` and both strobes are 0.
- R2: One system clock edge after `active_i` is sampled low, both counters are cleared, `sclk_o` equals `idle_high_i`, and both strobes are 0.
- R3: With `active_i` high and bypass off, the prescaler emits an advance tick at the c-th active edge exactly when c is a multiple of `pre_i + 1`. The prescaler count never exceeds `pre_i`.
- R4: The phase counter starts at 0 and steps once per tick, from `cnt_n_i` back to 0. With `cnt_h_i < cnt_l_i <= cnt_n_i`, the raw level becomes 1 at the tick on which the counter becomes `cnt_h_i` and becomes 0 at the tick on which it becomes `cnt_l_i`. The raw level is 0 after activation until the first of these ticks.
- R5: If `cnt_h_i == cnt_l_i`, setting high wins. The clock leaves idle once and stays there with no trailing strobe.
- R6: `sclk_o` equals the raw level XOR `idle_high_i`.
- R7: A leading strobe occurs in the cycle in which `sclk_o` leaves idle, and a trailing strobe in the cycle in which it returns. With `late_edge_i` = 0, `sample_o` is the leading strobe and `launch_o` the trailing one. With `late_edge_i` = 1 they swap. The two strobes are never high together outside bypass.
- R8: With `bypass_i` = 1, `sclk_o` = `idle_high_i` XOR (`active_i` AND `clk_i`). Both strobes equal `active_i`. The divider fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | Transaction in progress; clock runs while high |
| bypass_i | input | 1 | Serial clock equals system clock |
| idle_high_i | input | 1 | Idle level of the serial clock |
| late_edge_i | input | 1 | Phase select: 0 samples on leading edge, 1 on trailing |
| pre_i | input | PRE_W | Prescaler value minus one |
| cnt_n_i | input | CNT_W | Phase counter wrap value (cycle count minus one) |
| cnt_h_i | input | CNT_W | Count at which the clock leaves idle |
| cnt_l_i | input | CNT_W | Count at which the clock returns to idle |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle strobe: shift out next bit |
| sample_o | output | 1 | One-cycle strobe: capture input bit |

## Verification
Two events can land on the same tick. The prescaler tick that wraps the phase counter can also be the tick that makes the counter equal the high compare point; with `cnt_h_i` = 0 the wrap and the rising edge coincide on one edge. Separately, when the high and low compare points are equal, both compare matches occur on the same count. The sweep covers every ordered pair of compare points for several wrap and prescaler values, including `cnt_h_i` = 0 and `cnt_l_i` = `cnt_n_i`. It checks the clock level and both strobes in every cycle against an arithmetic model. A dedicated case with equal compare points checks that the high setting wins and that no trailing strobe appears.

// File: rtl/spi_sclk_pkg.sv
`timescale 1ns/1ps
package spi_sclk_pkg;
  localparam int unsigned PRE_W_DEF = 4;
  localparam int unsigned CNT_W_DEF = 6;

  typedef struct packed {
    logic lead;
    logic trail;
  } edge_flags_t;
endpackage

// File: rtl/spi_sclk_presc.sv
`timescale 1ns/1ps
module spi_sclk_presc #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] cnt_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= pre_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_sclk_phase.sv
`timescale 1ns/1ps
module spi_sclk_phase
  import spi_sclk_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] wrap_i,
  input  logic [CNT_W-1:0] hi_at_i,
  input  logic [CNT_W-1:0] lo_at_i,
  output logic             lvl_o,
  output edge_flags_t      edges_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             lvl_q;
  edge_flags_t      edges_q;

  // wrap also catches a count stranded above a lowered wrap value
  assign cnt_nxt = (cnt_q >= wrap_i) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      edges_q <= '0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      edges_q <= '0;
    end else begin
      edges_q <= '0;
      if (tick_i) begin
        cnt_q <= cnt_nxt;
        if (cnt_nxt == hi_at_i) begin
          lvl_q        <= 1'b1;
          edges_q.lead <= !lvl_q;
        end else if (cnt_nxt == lo_at_i) begin
          lvl_q         <= 1'b0;
          edges_q.trail <= lvl_q;
        end
      end
    end
  end

  assign lvl_o   = lvl_q;
  assign edges_o = edges_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/spi_sclk_outsel.sv
`timescale 1ns/1ps
module spi_sclk_outsel
  import spi_sclk_pkg::*;
(
  input  logic        clk_i,
  input  logic        active_i,
  input  logic        bypass_i,
  input  logic        idle_high_i,
  input  logic        late_edge_i,
  input  logic        lvl_i,
  input  edge_flags_t edges_i,
  output logic        sclk_o,
  output logic        launch_o,
  output logic        sample_o
);
  logic raw;

  assign raw    = bypass_i ? (active_i & clk_i) : lvl_i;
  assign sclk_o = raw ^ idle_high_i;

  always_comb begin
    if (bypass_i) begin
      launch_o = active_i;
      sample_o = active_i;
    end else if (late_edge_i) begin
      launch_o = edges_i.lead;
      sample_o = edges_i.trail;
    end else begin
      launch_o = edges_i.trail;
      sample_o = edges_i.lead;
    end
  end
endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int unsigned PRE_W = PRE_W_DEF,
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             bypass_i,
  input  logic             idle_high_i,
  input  logic             late_edge_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] cnt_n_i,
  input  logic [CNT_W-1:0] cnt_h_i,
  input  logic [CNT_W-1:0] cnt_l_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             sample_o
);
  logic             div_run, tick, lvl;
  logic [PRE_W-1:0] presc_cnt;
  logic [CNT_W-1:0] phase_cnt;
  edge_flags_t      edges;

  assign div_run = active_i & ~bypass_i;

  spi_sclk_presc #(.PRE_W(PRE_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (div_run),
    .pre_i (pre_i),
    .tick_o(tick),
    .cnt_o (presc_cnt)
  );

  spi_sclk_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (div_run),
    .tick_i (tick),
    .wrap_i (cnt_n_i),
    .hi_at_i(cnt_h_i),
    .lo_at_i(cnt_l_i),
    .lvl_o  (lvl),
    .edges_o(edges),
    .cnt_o  (phase_cnt)
  );

  spi_sclk_outsel u_outsel (
    .clk_i      (clk_i),
    .active_i   (active_i),
    .bypass_i   (bypass_i),
    .idle_high_i(idle_high_i),
    .late_edge_i(late_edge_i),
    .lvl_i      (lvl),
    .edges_i    (edges),
    .sclk_o     (sclk_o),
    .launch_o   (launch_o),
    .sample_o   (sample_o)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
`timescale 1ns/1ps
module spi_sclk_gen_chk #(
  parameter int unsigned PRE_W = 4,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             active_i,
  input logic             bypass_i,
  input logic             idle_high_i,
  input logic [PRE_W-1:0] pre_i,
  input logic [CNT_W-1:0] cnt_n_i,
  input logic [CNT_W-1:0] cnt_h_i,
  input logic [CNT_W-1:0] cnt_l_i,
  input logic             sclk_o,
  input logic             launch_o,
  input logic             sample_o,
  input logic [PRE_W-1:0] presc_cnt,
  input logic [CNT_W-1:0] phase_cnt
);
  a_r2_idle_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && !$past(active_i)) |-> (sclk_o == idle_high_i && !launch_o && !sample_o));

  a_r3_presc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pre_i) |-> (presc_cnt <= pre_i));

  a_r4_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cnt_n_i) |-> (phase_cnt <= cnt_n_i));

  a_r5_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i) && !bypass_i && !$past(bypass_i) && cnt_h_i == cnt_l_i &&
     $stable(cnt_h_i) && $stable(cnt_l_i) && $stable(idle_high_i) && $past(sclk_o) != idle_high_i)
    |-> (sclk_o != idle_high_i));

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_i |-> !(launch_o && sample_o));

  a_r7_strobe_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i) && !bypass_i && !$past(bypass_i) && $stable(idle_high_i) &&
     sclk_o != $past(sclk_o)) |-> (launch_o || sample_o));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .active_i   (active_i),
  .bypass_i   (bypass_i),
  .idle_high_i(idle_high_i),
  .pre_i      (pre_i),
  .cnt_n_i    (cnt_n_i),
  .cnt_h_i    (cnt_h_i),
  .cnt_l_i    (cnt_l_i),
  .sclk_o     (sclk_o),
  .launch_o   (launch_o),
  .sample_o   (sample_o),
  .presc_cnt  (presc_cnt),
  .phase_cnt  (phase_cnt)
);

// File: tb/spi_sclk_gen_bench.sv
`timescale 1ns/1ps
module spi_sclk_gen_bench;
  localparam int PRE_W = 4;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             active = 1'b0, bypass = 1'b0, idle_high = 1'b0, late_edge = 1'b0;
  logic [PRE_W-1:0] pre = '0;
  logic [CNT_W-1:0] cn = '0, ch = '0, cl = '0;
  logic             sclk, launch, sample;
  int               n_chk = 0, n_fail = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;

  spi_sclk_gen #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_spi_sclk_gen (
    .clk_i(clk), .rst_ni(rst_ni), .active_i(active), .bypass_i(bypass),
    .idle_high_i(idle_high), .late_edge_i(late_edge), .pre_i(pre),
    .cnt_n_i(cn), .cnt_h_i(ch), .cnt_l_i(cl),
    .sclk_o(sclk), .launch_o(launch), .sample_o(sample)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d (pre=%0d n=%0d h=%0d l=%0d)", req, act, exp, pre, cn, ch, cl);
    end
  endtask

  task automatic run_cfg(input int p, input int n, input int h, input int l, input int idx);
    int first_h;
    @(negedge clk);
    active = 0; pre = PRE_W'(p); cn = CNT_W'(n); ch = CNT_W'(h); cl = CNT_W'(l);
    idle_high = idx[0]; late_edge = idx[1];
    @(negedge clk);
    active = 1;
    first_h = (h == 0) ? n + 1 : h;
    for (int c = 1; c <= (p + 1) * (n + 1) * 3; c++) begin
      int  t, cnt;
      bit  tk, hi, lead, trail;
      @(negedge clk);
      t = c / (p + 1);
      cnt = t % (n + 1);
      tk = (c % (p + 1)) == 0;
      hi = (t >= first_h) && (cnt >= h) && (cnt < l);
      lead = tk && (cnt == h);
      trail = tk && (cnt == l) && (t > first_h);
      check("R3 R4 R6 sclk", sclk, idle_high ^ hi);
      check("R7 launch", launch, late_edge ? lead : trail);
      check("R7 sample", sample, late_edge ? trail : lead);
    end
    active = 0;
    @(negedge clk);
    check("R2 sclk idle after stop", sclk, idle_high);
    check("R2 strobes low after stop", {30'd0, launch, sample}, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int idx = 0;
    int leads, trails;
    #3;
    check("R1 sclk in reset", sclk, 0);
    check("R1 strobes in reset", {30'd0, launch, sample}, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    idle_high = 1;
    repeat (3) @(negedge clk);
    check("R1 sclk idle high inactive", sclk, 1);
    check("R1 strobes inactive", {30'd0, launch, sample}, 0);

    // full sweep of compare points
    for (int p = 0; p <= 2; p++)
      for (int n = 1; n <= 5; n++)
        for (int h = 0; h < n; h++)
          for (int l = h + 1; l <= n; l++) begin
            run_cfg(p, n, h, l, idx);
            idx++;
          end

    // R5: equal compare points
    @(negedge clk);
    pre = 0; cn = 3; ch = 2; cl = 2; idle_high = 0; late_edge = 1;
    @(negedge clk);
    active = 1;
    leads = 0; trails = 0;
    for (int c = 1; c <= 16; c++) begin
      @(negedge clk);
      leads += launch;
      trails += sample;
    end
    check("R5 clock stays high", sclk, 1);
    check("R5 one leading strobe", leads, 1);
    check("R5 no trailing strobe", trails, 0);
    active = 0;
    @(negedge clk);
    check("R2 sclk idle after R5 case", sclk, 0);

    // R8: bypass, with arbitrary divider fields
    pre = 3; cn = 5; ch = 1; cl = 2; idle_high = 1; bypass = 1;
    @(negedge clk);
    active = 1;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #2;
      check("R8 bypass sclk clk-high phase", sclk, 0);
      check("R8 bypass strobes", {30'd0, launch, sample}, 3);
      @(negedge clk); #1;
      check("R8 bypass sclk clk-low phase", sclk, 1);
    end
    active = 0;
    @(posedge clk); #2;
    check("R8 bypass inactive sclk", sclk, 1);
    check("R8 bypass inactive strobes", {30'd0, launch, sample}, 0);
    @(negedge clk);
    bypass = 0;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule